// File: doc/BRIEF.md
# Programmable Channel Delay Line

The block holds back a stream of 16-bit channel words by a programmable number of clock cycles. The stream is organised in two-clock timeslots. The block samples one word per timeslot into a circular buffer of 2048 entries. It sends that word out again a fixed number of timeslots later, so the latency is always an even number of clocks. The latency is 2·D + 2 cycles, where D is an 11-bit value. The largest D is 2047, which gives 4096 cycles.

The value D is loaded through a small select/strobe port. When the strobe falls while the select is low, the block takes the word on the delay address input. That value stays in force until the next such load. An active-low frame pulse marks the first clock of a timeslot, so the slot phase lines up with the channel boundaries. The pulse never clears the buffer or its pointer.

Top module: `chan_delay_line`

## Requirements
- R1: After reset, data_o is 0 and the programmed value D is 0, so the latency is 2 cycles until the first load.
- R2: With D programmed and input words held steady for both clocks of each timeslot, the word present in cycle c appears on data_o in cycle c + 2·D + 2.
- R3: D = 2047 gives a latency of 4096 cycles.
- R4: D is taken from addr_i in the cycle where strobe_ni is low, its value in the previous cycle was high, and cs_ni is low. The new latency applies from the following cycle. The old value is kept until such a load.
- R5: A strobe fall while cs_ni is high leaves D unchanged.
- R6: While strobe_ni stays low, changes on addr_i do not reload D. Only a falling edge loads.
- R7: A cycle with frame_ni low is the first clock of a timeslot. The slot is sampled on its second clock, and data_o changes only at the end of a slot's second clock. A pulse placed off the current phase moves the slot boundary to the pulse.
- R8: A frame pulse that falls on the existing slot boundary does not disturb the stream. The write pointer advances once per timeslot and is never cleared by the frame pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame pulse, active low; marks the first clock of a timeslot |
| data_i | input | 16 | Incoming channel word |
| addr_i | input | 11 | Delay value D, taken on a qualified strobe fall |
| cs_ni | input | 1 | Select, active low; qualifies the strobe |
| strobe_ni | input | 1 | Load strobe, active low; its falling edge loads D |
| data_o | output | 16 | Delayed channel word |

## Verification
A delay load and a frame-pulse realignment can land in the same clock. In that case the new latency and the shifted slot phase both begin on the next cycle. The bench provokes this by dropping strobe_ni, with select low, in the very cycle where it drives a frame pulse one clock off the current phase. After the buffer has refilled, it compares every output cycle against its own history of inputs, delayed by 2·D + 2 for the new D on the new slot grid. Any mismatch means one of the two events was lost or applied at the wrong phase.

// File: rtl/chdl_pkg.sv
package chdl_pkg;
  typedef enum logic {
    SLOT_HEAD = 1'b0,
    SLOT_TAIL = 1'b1
  } slot_phase_e;
endpackage

// File: rtl/chdl_slot_timer.sv
module chdl_slot_timer
  import chdl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  output logic slot_end_o
);
  slot_phase_e phase_q, phase_d;

  // frame pulse marks the head; next cycle is the tail
  always_comb begin
    if (!frame_ni) phase_d = SLOT_TAIL;
    else if (phase_q == SLOT_HEAD) phase_d = SLOT_TAIL;
    else phase_d = SLOT_HEAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= SLOT_HEAD;
    else         phase_q <= phase_d;
  end

  assign slot_end_o = (phase_q == SLOT_TAIL);

  AST_FRAME_SETS_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> slot_end_o) else $error("frame alignment lost"); // R7
  AST_PHASE_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ni |=> (slot_end_o != $past(slot_end_o))) else $error("phase stuck"); // R7
endmodule

// File: rtl/chdl_dly_reg.sv
module chdl_dly_reg #(
  parameter int unsigned DLY_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             strobe_ni,
  input  logic [DLY_W-1:0] addr_i,
  output logic [DLY_W-1:0] dly_o
);
  logic             stb_q;
  logic [DLY_W-1:0] dly_q;
  logic             load;

  assign load = !cs_ni && !strobe_ni && stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b1;
      dly_q <= '0;
    end else begin
      stb_q <= strobe_ni;
      if (load) dly_q <= addr_i;
    end
  end

  assign dly_o = dly_q;

  AST_LOAD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !strobe_ni && stb_q) |=> (dly_o == $past(addr_i))) else $error("load missed"); // R4
  AST_CS_BLOCKS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(dly_o)) else $error("load while deselected"); // R5
  AST_NO_RELOAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_ni && !stb_q) |=> $stable(dly_o)) else $error("level reload"); // R6
endmodule

// File: rtl/chdl_ring.sv
module chdl_ring #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DLY_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_end_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned DEPTH = 1 << DLY_W;
  typedef logic [DLY_W-1:0] ptr_t;

  logic [DATA_W-1:0] mem [DEPTH];
  ptr_t              wr_ptr_q;
  ptr_t              rd_ptr;
  logic [DATA_W-1:0] rd_word;
  logic              bypass;

  // entry written D slots ago; D=0 takes the word being written
  assign rd_ptr  = wr_ptr_q - dly_i;
  assign bypass  = (dly_i == '0);
  assign rd_word = bypass ? data_i : mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (slot_end_i) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      data_o   <= '0;
    end else if (slot_end_i) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      data_o   <= rd_word;
    end
  end

  AST_OUT_SLOT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> $stable(data_o)) else $error("output moved mid-slot"); // R7
  AST_WPTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_i |=> (wr_ptr_q == ptr_t'($past(wr_ptr_q) + 1'b1))) else $error("pointer skipped"); // R8
  AST_WPTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> $stable(wr_ptr_q)) else $error("pointer moved mid-slot"); // R8
endmodule

// File: rtl/chan_delay_line.sv
module chan_delay_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DLY_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DLY_W-1:0]  addr_i,
  input  logic              cs_ni,
  input  logic              strobe_ni,
  output logic [DATA_W-1:0] data_o
);
  logic             slot_end;
  logic [DLY_W-1:0] dly;

  chdl_slot_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ni   (frame_ni),
    .slot_end_o (slot_end)
  );

  chdl_dly_reg #(.DLY_W(DLY_W)) u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .strobe_ni (strobe_ni),
    .addr_i    (addr_i),
    .dly_o     (dly)
  );

  chdl_ring #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_end_i (slot_end),
    .dly_i      (dly),
    .data_i     (data_i),
    .data_o     (data_o)
  );

  AST_RESET_OUT: assert property (@(posedge clk_i)
    !rst_ni |=> (data_o == '0)) else $error("reset value"); // R1
endmodule

// File: tb/chan_delay_line_tb_top.sv
`timescale 1ns/1ps
module chan_delay_line_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1;
  logic [15:0] data_i = '0;
  logic [10:0] addr_i = '0;
  logic        cs_ni = 1'b1;
  logic        strobe_ni = 1'b1;
  logic [15:0] data_o;

  always #4 clk = ~clk;

  chan_delay_line dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_ni(frame_ni), .data_i(data_i),
    .addr_i(addr_i), .cs_ni(cs_ni), .strobe_ni(strobe_ni), .data_o(data_o)
  );

  int          checks = 0, fails = 0;
  int          cyc = 0, lat = 2, chk_from = 1 << 30;
  int          slot_cnt = 0, mism = 0;
  logic        ph_b = 1'b1;
  logic [15:0] hist [8192];
  logic [15:0] last_act, last_exp;
  logic [10:0] addr_b = '0;
  logic        cs_b = 1'b1, stb_b = 1'b1;
  bit          done = 0;

  function automatic logic [15:0] pat(int s);
    return 16'((s * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit fr);
    @(negedge clk);
    cyc++;
    if (cyc >= chk_from && cyc - lat >= 0) begin
      if (data_o !== hist[(cyc - lat) % 8192]) begin
        mism++;
        last_act = data_o;
        last_exp = hist[(cyc - lat) % 8192];
      end
    end
    frame_ni = fr ? 1'b0 : 1'b1;
    ph_b = fr ? 1'b0 : ~ph_b;
    if (!ph_b) slot_cnt++;
    data_i = pat(slot_cnt);
    cs_ni = cs_b; strobe_ni = stb_b; addr_i = addr_b;
    hist[cyc % 8192] = data_i;
  endtask

  task automatic settle();
    while (cyc < chk_from) step(1'b0);
  endtask

  task automatic window(int n, string req);
    mism = 0;
    repeat (n) step(1'b0);
    check(mism == 0, req, int'(last_act), int'(last_exp));
  endtask

  task automatic load(int d, bit sel);
    addr_b = 11'(d); cs_b = ~sel; stb_b = 1'b0;
    step(1'b0);
    if (sel) begin lat = 2 * d + 2; chk_from = cyc + lat + 8; end
    step(1'b0); step(1'b0);
    stb_b = 1'b1; cs_b = 1'b1;
    step(1'b0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(data_o == 16'h0, "R1 reset output", int'(data_o), 0);
    rst_ni = 1'b1;
    step(1'b1);
    lat = 2; chk_from = cyc + 8;
    settle();
    window(200, "R1 default latency");
    window(100, "R2 latency D=0");
  endtask

  task automatic t_program();
    load(5, 1'b1);
    settle();
    window(300, "R2 latency D=5");
    window(100, "R4 value held");
  endtask

  task automatic t_deselected();
    load(9, 1'b0);
    window(100, "R5 deselected strobe");
  endtask

  task automatic t_hold_low();
    addr_b = 11'd7; cs_b = 1'b0; stb_b = 1'b0;
    step(1'b0);
    lat = 16; chk_from = cyc + lat + 8;
    addr_b = 11'd20;
    repeat (5) step(1'b0);
    stb_b = 1'b1; cs_b = 1'b1;
    step(1'b0);
    settle();
    window(200, "R6 no level reload");
  endtask

  task automatic t_max();
    load(2047, 1'b1);
    settle();
    window(600, "R3 latency 4096");
    load(3, 1'b1);
    settle();
    window(100, "R4 reload after max");
  endtask

  task automatic t_aligned_frames();
    mism = 0;
    for (int k = 0; k < 40; k++) begin
      while (ph_b != 1'b1) step(1'b0);
      step(1'b1);
      repeat (19) step(1'b0);
    end
    check(mism == 0, "R8 aligned frame pulses", int'(last_act), int'(last_exp));
  endtask

  task automatic t_realign();
    while (ph_b != 1'b0) step(1'b0);
    step(1'b1);
    chk_from = cyc + lat + 8;
    settle();
    window(200, "R7 realigned slots");
  endtask

  task automatic t_load_and_frame();
    while (ph_b != 1'b0) step(1'b0);
    addr_b = 11'd1; cs_b = 1'b0; stb_b = 1'b0;
    step(1'b1);
    lat = 4; chk_from = cyc + lat + 8;
    stb_b = 1'b1; cs_b = 1'b1;
    step(1'b0);
    settle();
    window(200, "R4 load with frame");
    window(100, "R7 frame with load");
  endtask

  initial begin
    t_reset();
    t_program();
    t_deselected();
    t_hold_low();
    t_max();
    t_aligned_frames();
    t_realign();
    t_load_and_frame();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule